// File: doc/BRIEF.md
# Partial-Width Register Alias Table

This block renames a group of up to three micro-ops each cycle for eight integer architectural registers. Every register name resolves either to the committed (retired) register file or to a reorder-buffer slot. The slot is identified by a 6-bit tag, because there are 40 slots. A source operand carries a register number and an access size. Each destination carries the physical tag handed over by the allocator. The block returns, for every source, a physical tag and a flag that says whether the value lives in the retired file.

Byte-level aliasing uses two mapping banks. The low bank has eight entries and serves full, 16-bit and low-byte accesses. The high bank has four entries, one for each of registers 0..3, and serves their high-byte halves. A read that is wider than a still-speculative narrower write to the same register cannot be assembled from one slot. When any op in a group makes such a read, the block raises a stall and the whole group is held back. A register that was cleared by a zeroing idiom is exempt from this stall.

Retirement ports put entries back to the retired file. A flush, used on a mispredict, resets every mapping.

Top module: `rat_partial_rename`

## Requirements
- R1: After reset, every source lookup of every register and size reports the retired-file flag set.
- R2: After a group is accepted, a source that reads a register written in that group returns the writer's 6-bit tag with the retired-file flag clear.
- R3: Within one group, a source of op i that reads a register written by an earlier op j < i returns the tag of the latest such earlier op, with the flag clear.
- R4: Size encoding: 00 = 32-bit, 01 = 16-bit, 10 = low byte, 11 = high byte (high bank index = register number bits [1:0]). 32/16-bit writes update both banks (the high bank only for registers 0..3). A low-byte write updates only the low bank, and a high-byte write updates only the high bank. High-byte reads use the high bank; all other reads use the low bank.
- R5: `rename_stall` is high when a valid op reads a register at 32 bits whose unretired low mapping came from a 16-bit or low-byte write. It is also high for a 16-bit read of an unretired low-byte write, and for a 32/16-bit read of a register whose unretired high mapping came from a high-byte write. Earlier ops in the same group count. A stalled group changes no mapping.
- R6: Low-byte and high-byte reads never cause a stall, and neither does a high-byte read after a 32/16-bit write.
- R7: A retire port with a valid tag sets back to the retired file only those entries whose current tag equals it. The effect is visible to lookups in the same cycle, and entries holding a newer tag are untouched.
- R8: A flush resets every mapping to the retired file on the next edge and discards the group presented in that cycle.
- R9: A 32/16-bit write flagged as a zeroing idiom marks the register so that a later wide read of it does not stall after narrower writes, until the register retires or is rewritten wide without the flag.
- R10: An op whose valid bit is low neither stalls the group nor updates any mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Reset all mappings to the retired file |
| ren_valid | input | 3 | Op valid, one bit per group slot |
| ren_src_reg | input | 3x2x3 | Source register numbers, [op][source] |
| ren_src_size | input | 3x2x2 | Source access sizes, [op][source] |
| ren_dst_valid | input | 3 | Op writes a destination |
| ren_dst_reg | input | 3x3 | Destination register numbers |
| ren_dst_size | input | 3x2 | Destination access sizes |
| ren_zero_idiom | input | 3 | Op is a zeroing idiom |
| ren_dst_tag | input | 3x6 | Reorder-buffer tag from the allocator |
| ret_valid | input | 3 | Retire port valid |
| ret_tag | input | 3x6 | Tag of the retiring op |
| src_tag | output | 3x2x6 | Physical tag for each source |
| src_in_rrf | output | 3x2 | Source reads the retired file |
| rename_stall | output | 1 | Group must be held and re-presented |

## Verification
A corrupted mapping entry appears on the next lookup of that register: the cycle after the writing group is accepted, the wrong tag or retired-file flag shows directly on `src_tag` and `src_in_rrf`. A lost width or zeroing marker shows only when a later wider read arrives, so the bench pairs each narrow write with a wide read and sees `rename_stall` in that same cycle. Retirement and flush faults show as a stale tag or a cleared flag one edge later.

// File: rtl/rat_pkg.sv
package rat_pkg;

    localparam int ARCH_REGS = 8;
    localparam int HIGH_REGS = 4;
    localparam int ROB_SLOTS = 40;
    localparam int TAG_W     = $clog2(ROB_SLOTS);
    localparam int AREG_W    = $clog2(ARCH_REGS);
    localparam int HIDX_W    = $clog2(HIGH_REGS);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [AREG_W-1:0] areg_t;

    typedef enum logic [1:0] {
        SZ_32 = 2'b00,
        SZ_16 = 2'b01,
        SZ_LO = 2'b10,
        SZ_HI = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic      in_rrf;
        tag_t      tag;
        acc_size_e width;
        logic      zeroed;
    } low_map_t;

    typedef struct packed {
        logic in_rrf;
        tag_t tag;
        logic byte_only;
    } high_map_t;

    typedef struct packed {
        low_map_t  [ARCH_REGS-1:0] lo;
        high_map_t [HIGH_REGS-1:0] hi;
    } map_table_t;

    function automatic map_table_t fresh_table();
        map_table_t t;
        for (int e = 0; e < ARCH_REGS; e++) begin
            t.lo[e] = '{in_rrf: 1'b1, tag: '0, width: SZ_32, zeroed: 1'b0};
        end
        for (int e = 0; e < HIGH_REGS; e++) begin
            t.hi[e] = '{in_rrf: 1'b1, tag: '0, byte_only: 1'b0};
        end
        return t;
    endfunction

    function automatic logic is_wide(acc_size_e s);
        return (s == SZ_32) || (s == SZ_16);
    endfunction

    function automatic logic has_high(areg_t r);
        return int'(r) < HIGH_REGS;
    endfunction

endpackage

// File: rtl/rat_retire.sv
module rat_retire
    import rat_pkg::*;
#(
    parameter int RET_W = 3
) (
    input  map_table_t             tbl_in,
    input  logic [RET_W-1:0]       ret_valid,
    input  tag_t [RET_W-1:0]       ret_tag,
    output map_table_t             tbl_out
);

    always_comb begin
        tbl_out = tbl_in;
        for (int k = 0; k < RET_W; k++) begin
            if (ret_valid[k]) begin
                for (int e = 0; e < ARCH_REGS; e++) begin
                    if (!tbl_in.lo[e].in_rrf && tbl_in.lo[e].tag == ret_tag[k]) begin
                        tbl_out.lo[e].in_rrf = 1'b1;
                        tbl_out.lo[e].zeroed = 1'b0;
                    end
                end
                for (int e = 0; e < HIGH_REGS; e++) begin
                    if (!tbl_in.hi[e].in_rrf && tbl_in.hi[e].tag == ret_tag[k]) begin
                        tbl_out.hi[e].in_rrf    = 1'b1;
                        tbl_out.hi[e].byte_only = 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rat_apply.sv
module rat_apply
    import rat_pkg::*;
(
    input  map_table_t tbl_in,
    input  logic       en,
    input  areg_t      dst_reg,
    input  acc_size_e  dst_size,
    input  logic       zero_idiom,
    input  tag_t       dst_tag,
    output map_table_t tbl_out
);

    logic [HIDX_W-1:0] hidx;
    assign hidx = dst_reg[HIDX_W-1:0];

    always_comb begin
        tbl_out = tbl_in;
        if (en) begin
            case (dst_size)
                SZ_32, SZ_16: begin
                    tbl_out.lo[dst_reg] = '{in_rrf: 1'b0, tag: dst_tag,
                                            width: dst_size, zeroed: zero_idiom};
                    if (has_high(dst_reg)) begin
                        tbl_out.hi[hidx] = '{in_rrf: 1'b0, tag: dst_tag, byte_only: 1'b0};
                    end
                end
                SZ_LO: begin
                    tbl_out.lo[dst_reg] = '{in_rrf: 1'b0, tag: dst_tag, width: SZ_LO,
                        zeroed: tbl_in.lo[dst_reg].zeroed && !tbl_in.lo[dst_reg].in_rrf};
                end
                default: begin
                    tbl_out.hi[hidx] = '{in_rrf: 1'b0, tag: dst_tag, byte_only: 1'b1};
                end
            endcase
        end
    end

endmodule

// File: rtl/rat_lookup.sv
module rat_lookup
    import rat_pkg::*;
(
    input  map_table_t tbl,
    input  areg_t      src_reg,
    input  acc_size_e  src_size,
    output tag_t       tag,
    output logic       in_rrf,
    output logic       hazard
);

    low_map_t  lo_e;
    high_map_t hi_e;
    logic      narrow_lo;
    logic      narrow_hi;

    assign lo_e = tbl.lo[src_reg];
    assign hi_e = tbl.hi[src_reg[HIDX_W-1:0]];

    always_comb begin
        if (src_size == SZ_HI) begin
            tag    = hi_e.tag;
            in_rrf = hi_e.in_rrf;
        end else begin
            tag    = lo_e.tag;
            in_rrf = lo_e.in_rrf;
        end
        narrow_lo = !lo_e.in_rrf &&
                    (((src_size == SZ_32) && (lo_e.width != SZ_32)) ||
                     ((src_size == SZ_16) && (lo_e.width == SZ_LO)));
        narrow_hi = has_high(src_reg) && !hi_e.in_rrf && hi_e.byte_only && is_wide(src_size);
        hazard    = (narrow_lo || narrow_hi) && !lo_e.zeroed;
    end

endmodule

// File: rtl/rat_partial_rename.sv
module rat_partial_rename
    import rat_pkg::*;
#(
    parameter int WIDTH = 3,
    parameter int N_SRC = 2,
    parameter int RET_W = 3
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  flush,
    input  logic [WIDTH-1:0]                      ren_valid,
    input  logic [WIDTH-1:0][N_SRC-1:0][AREG_W-1:0] ren_src_reg,
    input  logic [WIDTH-1:0][N_SRC-1:0][1:0]      ren_src_size,
    input  logic [WIDTH-1:0]                      ren_dst_valid,
    input  logic [WIDTH-1:0][AREG_W-1:0]          ren_dst_reg,
    input  logic [WIDTH-1:0][1:0]                 ren_dst_size,
    input  logic [WIDTH-1:0]                      ren_zero_idiom,
    input  logic [WIDTH-1:0][TAG_W-1:0]           ren_dst_tag,
    input  logic [RET_W-1:0]                      ret_valid,
    input  logic [RET_W-1:0][TAG_W-1:0]           ret_tag,
    output logic [WIDTH-1:0][N_SRC-1:0][TAG_W-1:0] src_tag,
    output logic [WIDTH-1:0][N_SRC-1:0]           src_in_rrf,
    output logic                                  rename_stall
);

    map_table_t state_q;
    map_table_t state_d;
    map_table_t chain [WIDTH+1];
    logic [WIDTH-1:0][N_SRC-1:0] haz;
    logic [WIDTH-1:0]            op_stall;
    logic                        all_rrf;

    rat_retire #(.RET_W(RET_W)) u_retire (
        .tbl_in   (state_q),
        .ret_valid(ret_valid),
        .ret_tag  (ret_tag),
        .tbl_out  (chain[0])
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_op
        rat_apply u_apply (
            .tbl_in    (chain[i]),
            .en        (ren_valid[i] && ren_dst_valid[i]),
            .dst_reg   (ren_dst_reg[i]),
            .dst_size  (acc_size_e'(ren_dst_size[i])),
            .zero_idiom(ren_zero_idiom[i]),
            .dst_tag   (ren_dst_tag[i]),
            .tbl_out   (chain[i+1])
        );
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            rat_lookup u_look (
                .tbl     (chain[i]),
                .src_reg (ren_src_reg[i][s]),
                .src_size(acc_size_e'(ren_src_size[i][s])),
                .tag     (src_tag[i][s]),
                .in_rrf  (src_in_rrf[i][s]),
                .hazard  (haz[i][s])
            );
        end
        assign op_stall[i] = ren_valid[i] && (|haz[i]);
    end

    assign rename_stall = |op_stall;

    always_comb begin
        if (flush) begin
            state_d = fresh_table();
        end else if ((|ren_valid) && !rename_stall) begin
            state_d = chain[WIDTH];
        end else begin
            state_d = chain[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= fresh_table();
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        all_rrf = 1'b1;
        for (int e = 0; e < ARCH_REGS; e++) all_rrf &= state_q.lo[e].in_rrf;
        for (int e = 0; e < HIGH_REGS; e++) all_rrf &= state_q.hi[e].in_rrf;
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        (rename_stall && !flush && !(|ret_valid)) |=> $stable(state_q)); // R5

    AST_FLUSH_TO_RRF: assert property (@(posedge clk) disable iff (rst)
        flush |=> all_rrf); // R8

    AST_GROUP_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        (ren_valid[0] && ren_valid[1] && ren_dst_valid[0] &&
         ren_dst_size[0] == 2'b00 && ren_src_size[1][0] != 2'b11 &&
         ren_src_reg[1][0] == ren_dst_reg[0])
        |-> (src_tag[1][0] == ren_dst_tag[0] && !src_in_rrf[1][0])); // R3

    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        !(|ren_valid) |-> !rename_stall); // R10

    AST_BYTE_READ_SAFE: assert property (@(posedge clk) disable iff (rst)
        (ren_valid == 3'b001 && ren_src_size[0][0][1] && ren_src_size[0][1][1])
        |-> !rename_stall); // R6

endmodule

// File: tb/sim_rat_partial_rename.sv
`timescale 1ns/1ps
module sim_rat_partial_rename;
    import rat_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic flush;
    logic [2:0]            ren_valid;
    logic [2:0][1:0][2:0]  ren_src_reg;
    logic [2:0][1:0][1:0]  ren_src_size;
    logic [2:0]            ren_dst_valid;
    logic [2:0][2:0]       ren_dst_reg;
    logic [2:0][1:0]       ren_dst_size;
    logic [2:0]            ren_zero_idiom;
    logic [2:0][5:0]       ren_dst_tag;
    logic [2:0]            ret_valid;
    logic [2:0][5:0]       ret_tag;
    logic [2:0][1:0][5:0]  src_tag;
    logic [2:0][1:0]       src_in_rrf;
    logic                  rename_stall;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    localparam logic [1:0] S32 = 2'b00, S16 = 2'b01, SLO = 2'b10, SHI = 2'b11;

    rat_partial_rename u0 (
        .clk(clk), .rst(rst), .flush(flush),
        .ren_valid(ren_valid), .ren_src_reg(ren_src_reg), .ren_src_size(ren_src_size),
        .ren_dst_valid(ren_dst_valid), .ren_dst_reg(ren_dst_reg), .ren_dst_size(ren_dst_size),
        .ren_zero_idiom(ren_zero_idiom), .ren_dst_tag(ren_dst_tag),
        .ret_valid(ret_valid), .ret_tag(ret_tag),
        .src_tag(src_tag), .src_in_rrf(src_in_rrf), .rename_stall(rename_stall)
    );

    always #4 clk = ~clk;

    task automatic clear_inputs();
        flush = 0; ren_valid = '0; ren_dst_valid = '0; ren_zero_idiom = '0;
        ren_dst_tag = '0; ren_dst_reg = '0; ren_dst_size = '0;
        ret_valid = '0; ret_tag = '0;
        for (int i = 0; i < 3; i++)
            for (int s = 0; s < 2; s++) begin
                ren_src_reg[i][s] = 3'd7; ren_src_size[i][s] = SLO;
            end
    endtask

    task automatic src(int i, int s, int r, logic [1:0] sz);
        ren_valid[i] = 1'b1; ren_src_reg[i][s] = 3'(r); ren_src_size[i][s] = sz;
    endtask

    task automatic dst(int i, int r, logic [1:0] sz, int tag, bit zi);
        ren_valid[i] = 1'b1; ren_dst_valid[i] = 1'b1; ren_dst_reg[i] = 3'(r);
        ren_dst_size[i] = sz; ren_dst_tag[i] = 6'(tag); ren_zero_idiom[i] = zi;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
        clear_inputs();
    endtask

    task automatic chk_src(string req, int i, int s, int etag, bit erff, bit use_tag);
        #1;
        n_checks++;
        if (src_in_rrf[i][s] !== erff || (use_tag && src_tag[i][s] !== 6'(etag))) begin
            n_fails++;
            $display("FAIL %s op%0d src%0d: tag=%0d rrf=%0b expected tag=%0d rrf=%0b",
                     req, i, s, src_tag[i][s], src_in_rrf[i][s], etag, erff);
        end
    endtask

    task automatic chk_stall(string req, bit exp);
        #1;
        n_checks++;
        if (rename_stall !== exp) begin
            n_fails++;
            $display("FAIL %s stall: actual=%0b expected=%0b", req, rename_stall, exp);
        end
    endtask

    task automatic t_reset();
        src(0, 0, 0, S32); src(0, 1, 3, SHI); src(1, 0, 7, S16);
        chk_src("R1", 0, 0, 0, 1, 0);
        chk_src("R1", 0, 1, 0, 1, 0);
        chk_src("R1", 1, 0, 0, 1, 0);
        chk_stall("R1", 0);
        step();
    endtask

    task automatic t_basic();
        dst(0, 0, S32, 5, 0); dst(1, 1, S16, 6, 0); dst(2, 2, SLO, 7, 0);
        step();
        src(0, 0, 0, S32); src(0, 1, 0, SHI);
        src(1, 0, 1, S16); src(1, 1, 1, SHI);
        src(2, 0, 2, SLO); src(2, 1, 2, SHI);
        chk_src("R2", 0, 0, 5, 0, 1);
        chk_src("R4", 0, 1, 5, 0, 1);
        chk_src("R2", 1, 0, 6, 0, 1);
        chk_src("R4", 1, 1, 6, 0, 1);
        chk_src("R2", 2, 0, 7, 0, 1);
        chk_src("R4", 2, 1, 0, 1, 0);
        chk_stall("R6", 0);
        step();
    endtask

    task automatic t_stall_lowbyte();
        src(0, 0, 2, S32); src(0, 1, 2, S16);
        dst(1, 3, S32, 9, 0);
        chk_stall("R5", 1);
        step();
        src(0, 0, 3, S32);
        chk_src("R5", 0, 0, 0, 1, 0);
        chk_stall("R5", 0);
        step();
    endtask

    task automatic t_high_byte();
        dst(0, 3, SHI, 10, 0);
        step();
        src(0, 0, 3, SLO); src(0, 1, 3, SHI);
        chk_src("R4", 0, 0, 0, 1, 0);
        chk_src("R4", 0, 1, 10, 0, 1);
        chk_stall("R6", 0);
        step();
        src(0, 0, 3, S16);
        chk_stall("R5", 1);
        step();
    endtask

    task automatic t_retire();
        ret_valid[0] = 1'b1; ret_tag[0] = 6'd7;
        src(0, 0, 2, S32); src(0, 1, 2, SLO);
        chk_src("R7", 0, 0, 0, 1, 0);
        chk_src("R7", 0, 1, 0, 1, 0);
        chk_stall("R7", 0);
        step();
        dst(0, 0, S32, 11, 0);
        step();
        ret_valid[2] = 1'b1; ret_tag[2] = 6'd5;
        src(0, 0, 0, S32); src(0, 1, 0, SHI);
        chk_src("R7", 0, 0, 11, 0, 1);
        chk_src("R7", 0, 1, 11, 0, 1);
        step();
    endtask

    task automatic t_override();
        dst(0, 4, S32, 12, 0);
        src(1, 0, 4, S32); src(1, 1, 1, SHI); dst(1, 4, S16, 13, 0);
        src(2, 0, 4, S16);
        chk_src("R3", 1, 0, 12, 0, 1);
        chk_src("R4", 1, 1, 6, 0, 1);
        chk_src("R3", 2, 0, 13, 0, 1);
        chk_stall("R3", 0);
        step();
        src(0, 0, 4, S32);
        chk_src("R2", 0, 0, 13, 0, 1);
        chk_stall("R5", 1);
        step();
    endtask

    task automatic t_group_stall();
        dst(0, 6, SLO, 16, 0);
        src(1, 0, 6, S32);
        chk_stall("R5", 1);
        step();
        src(0, 0, 6, SLO);
        chk_src("R5", 0, 0, 0, 1, 0);
        step();
    endtask

    task automatic t_zero_idiom();
        dst(0, 5, S32, 14, 1);
        dst(1, 5, SLO, 15, 0);
        src(2, 0, 5, S32);
        chk_src("R9", 2, 0, 15, 0, 1);
        chk_stall("R9", 0);
        step();
        src(0, 0, 5, S32);
        chk_src("R9", 0, 0, 15, 0, 1);
        chk_stall("R9", 0);
        step();
    endtask

    task automatic t_invalid_op();
        dst(0, 7, S32, 21, 0); src(0, 0, 4, S32);
        ren_valid[0] = 1'b0;
        chk_stall("R10", 0);
        step();
        src(0, 0, 7, SLO);
        chk_src("R10", 0, 0, 0, 1, 0);
        step();
    endtask

    task automatic t_flush();
        flush = 1'b1;
        dst(0, 6, S32, 20, 0);
        step();
        src(0, 0, 0, S32); src(0, 1, 4, SHI);
        src(1, 0, 6, S32); src(1, 1, 1, SHI);
        src(2, 0, 4, S32);
        chk_src("R8", 0, 0, 0, 1, 0);
        chk_src("R8", 0, 1, 0, 1, 0);
        chk_src("R8", 1, 0, 0, 1, 0);
        chk_src("R8", 1, 1, 0, 1, 0);
        chk_stall("R8", 0);
        step();
    endtask

    initial begin
        clear_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_stall_lowbyte();
        t_high_byte();
        t_retire();
        t_override();
        t_group_stall();
        t_zero_idiom();
        t_invalid_op();
        t_flush();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule